// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the processor-facing register set of a PS/2 keyboard or mouse port. A simple word-addressed bus reaches six things through it: a control word, a status word, a data word, a clock-divider word, an interrupt-status word and a read-only identification window at the top of a 4 KB address space. Behind it sits a byte-stream device port. Received bytes arrive with a valid/ready handshake, and transmitted bytes leave as a single-cycle strobe.

A received byte counts as pending for as long as the device port holds it valid. Software reads the data word to take the byte. The read pulses ready for one cycle and keeps a copy of the byte. When nothing is pending, the copy is returned again. Status parity is worked out from that copy, so it describes the byte software last saw, not the one now waiting. One interrupt line combines pending with a receive-enable control bit, and a second control bit forces the line high.

Read data is registered: it appears on the read-data port in the cycle after read enable is sampled. The clock-divider word is storage only. The line-level serializer and the use of the divider are outside this block.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset the control word, clock-divider word and data word read 0, status reads 0x40, interrupt status reads 0x02, and the interrupt line is low.
- R2: The control word (byte offset 0x000) and the clock-divider word (0x00C) read back what was last written, and read data appears one cycle after the read is sampled.
- R3: Status (0x004) has bit 6 = 1 (transmit empty), bit 4 = pending, and bit 2 = XOR of all 8 bits of the last data byte returned. Every other bit reads 0.
- R4: A data-word read (0x008) while a byte is pending returns that byte, raises rx_ready_o for that cycle only, and keeps the byte as the last data byte.
- R5: A data-word read with nothing pending returns the last data byte again and leaves rx_ready_o low. rx_ready_o is never high outside a data-word read.
- R6: irq_o = (pending AND control bit 4) OR control bit 3. It follows control writes and changes of pending without delay.
- R7: Interrupt status (0x010) reads the pending flag in bit 0 and 1 in bit 1. All other bits read 0.
- R8: A write to the data word puts write-data bits 7:0 on tx_byte_o with tx_strobe_o high for exactly the next cycle. No other access raises tx_strobe_o.
- R9: Reads at byte offsets 0xFE0 to 0xFFF return entry (offset-0xFE0)/4 of the table 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Every other offset reads 0, and writes to it change no register and send nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Byte address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 32 | Read data, registered |
| rx_byte_i | input | 8 | Received byte from device port |
| rx_valid_i | input | 1 | Received byte pending |
| rx_ready_o | output | 1 | Received byte consumed |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_strobe_o | output | 1 | Transmit byte valid, one cycle |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the handshake and strobe rules on every cycle. They confirm that ready never rises without valid or outside a data read, that a consumed byte becomes the stored copy, that every data write yields exactly one strobe carrying its low byte, that the divider changes only when written, and that the force bit always drives the interrupt. Only the bench's scenarios can show the value-level behaviour. This covers parity, which tracks the byte last read rather than the pending one, repeated reads with an empty port, back-to-back pops from a two-byte stream, the contents of the identification window, and unmapped offsets that read zero and absorb writes.

// File: rtl/ps2_regs_pkg.sv
package ps2_regs_pkg;
  localparam int W_CTRL   = 0;
  localparam int W_STAT   = 1;
  localparam int W_DATA   = 2;
  localparam int W_DIV    = 3;
  localparam int W_IRQST  = 4;

  localparam int ST_TXEMPTY = 6;
  localparam int ST_RXFULL  = 4;
  localparam int ST_RXPAR   = 2;

  localparam int CTRL_RXIE  = 4;
  localparam int CTRL_FORCE = 3;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h50;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2_reg_file.sv
module ps2_reg_file #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_div_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] div_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      div_o  <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_o <= wdata_i;
      if (wr_div_i)  div_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/ps2_rx_latch.sv
module ps2_rx_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] view_o,
  output logic [BYTE_W-1:0] last_o,
  output logic              parity_o
);
  logic take;
  assign take       = pop_i & rx_valid_i;
  assign rx_ready_o = take;
  // byte the current read returns: fresh when consumed, else the kept copy
  assign view_o     = take ? rx_byte_i : last_o;
  assign parity_o   = ^last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_o <= '0;
    else if (take) last_o <= rx_byte_i;
  end
endmodule

// File: rtl/ps2_tx_port.sv
module ps2_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              send_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_strobe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_byte_o   <= '0;
      tx_strobe_o <= 1'b0;
    end else begin
      tx_strobe_o <= send_i;
      if (send_i) tx_byte_o <= byte_i;
    end
  end
endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_re_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_byte_o,
  output logic              tx_strobe_o,
  output logic              irq_o
);
  import ps2_regs_pkg::*;

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              id_hit;
  logic [2:0]        id_idx;
  logic              addr_lsb_unused;

  assign word            = bus_addr_i[ADDR_W-1:2];
  assign id_hit          = &bus_addr_i[ADDR_W-1:5];
  assign id_idx          = bus_addr_i[4:2];
  assign addr_lsb_unused = ^bus_addr_i[1:0];

  logic wr_ctrl, wr_div, wr_data, rd_data;
  assign wr_ctrl = bus_we_i && (word == WORD_W'(W_CTRL));
  assign wr_div  = bus_we_i && (word == WORD_W'(W_DIV));
  assign wr_data = bus_we_i && (word == WORD_W'(W_DATA));
  assign rd_data = bus_re_i && (word == WORD_W'(W_DATA));

  logic [DATA_W-1:0] ctrl_q, clkdiv_q;
  logic [BYTE_W-1:0] view_byte, last_q;
  logic              parity;

  ps2_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_ctrl),
    .wr_div_i  (wr_div),
    .wdata_i   (bus_wdata_i),
    .ctrl_o    (ctrl_q),
    .div_o     (clkdiv_q)
  );

  ps2_rx_latch #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pop_i      (rd_data),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .rx_ready_o (rx_ready_o),
    .view_o     (view_byte),
    .last_o     (last_q),
    .parity_o   (parity)
  );

  ps2_tx_port #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_i      (wr_data),
    .byte_i      (bus_wdata_i[BYTE_W-1:0]),
    .tx_byte_o   (tx_byte_o),
    .tx_strobe_o (tx_strobe_o)
  );

  assign irq_o = (rx_valid_i & ctrl_q[CTRL_RXIE]) | ctrl_q[CTRL_FORCE];

  logic [DATA_W-1:0] stat_w, irqst_w, rd_mux;

  always_comb begin
    stat_w              = '0;
    stat_w[ST_TXEMPTY]  = 1'b1;
    stat_w[ST_RXFULL]   = rx_valid_i;
    stat_w[ST_RXPAR]    = parity;
    irqst_w             = '0;
    irqst_w[0]          = rx_valid_i;
    irqst_w[1]          = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    if (id_hit) begin
      rd_mux = DATA_W'(id_byte(id_idx));
    end else begin
      case (word)
        WORD_W'(W_CTRL):  rd_mux = ctrl_q;
        WORD_W'(W_STAT):  rd_mux = stat_w;
        WORD_W'(W_DATA):  rd_mux = DATA_W'(view_byte);
        WORD_W'(W_DIV):   rd_mux = clkdiv_q;
        WORD_W'(W_IRQST): rd_mux = irqst_w;
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= rd_mux;
  end
endmodule

// File: rtl/ps2_port_regs_chk.sv
module ps2_port_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-3:0] word_i,
  input logic              we_i,
  input logic              re_i,
  input logic [BYTE_W-1:0] wbyte_i,
  input logic              rx_valid_i,
  input logic [BYTE_W-1:0] rx_byte_i,
  input logic              rx_ready_i,
  input logic [BYTE_W-1:0] tx_byte_i,
  input logic              tx_strobe_i,
  input logic              irq_i,
  input logic              force_i,
  input logic [BYTE_W-1:0] last_i,
  input logic [DATA_W-1:0] clkdiv_i
);
  logic is_data, is_div;
  assign is_data = (word_i == (ADDR_W-2)'(2));
  assign is_div  = (word_i == (ADDR_W-2)'(3));

  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i |-> rx_valid_i); // R4

  AST_READY_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i |-> (re_i && is_data)); // R5

  AST_POP_KEEPS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i |=> (last_i == $past(rx_byte_i))); // R4

  AST_TX_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && is_data) |=> (tx_strobe_i && tx_byte_i == $past(wbyte_i))); // R8

  AST_TX_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && is_data) |=> !tx_strobe_i); // R8

  AST_DIV_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && is_div) |=> $stable(clkdiv_i)); // R2

  AST_IRQ_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> irq_i); // R6
endmodule

bind ps2_port_regs ps2_port_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_i      (bus_addr_i[ADDR_W-1:2]),
  .we_i        (bus_we_i),
  .re_i        (bus_re_i),
  .wbyte_i     (bus_wdata_i[BYTE_W-1:0]),
  .rx_valid_i  (rx_valid_i),
  .rx_byte_i   (rx_byte_i),
  .rx_ready_i  (rx_ready_o),
  .tx_byte_i   (tx_byte_o),
  .tx_strobe_i (tx_strobe_o),
  .irq_i       (irq_o),
  .force_i     (ctrl_q[3]),
  .last_i      (last_q),
  .clkdiv_i    (clkdiv_q)
);

// File: tb/tb_ps2_port_regs.sv
module tb_ps2_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_strobe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ps2_port_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_re_i(re), .bus_rdata_o(rdata),
    .rx_byte_i(rx_byte), .rx_valid_i(rx_valid), .rx_ready_o(rx_ready),
    .tx_byte_o(tx_byte), .tx_strobe_o(tx_strobe), .irq_o(irq)
  );

  // device-side byte source
  logic [7:0] dev_q[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_valid <= 1'b0;
    else if (!rx_valid || rx_ready) begin
      if (dev_q.size() > 0) begin
        rx_valid <= 1'b1;
        rx_byte  <= dev_q.pop_front();
      end else rx_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  always @(posedge clk) rd_seen <= re;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input bit exp_rdy, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    #1 chk(rx_ready === exp_rdy, {tag, " ready"}, {31'b0, rx_ready}, {31'b0, exp_rdy});
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_tx, input string tag);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
    chk(tx_strobe === exp_tx, {tag, " strobe"}, {31'b0, tx_strobe}, {31'b0, exp_tx});
    if (exp_tx) chk(tx_byte === d[7:0], {tag, " byte"}, {24'b0, tx_byte}, {24'b0, d[7:0]});
    @(negedge clk);
    chk(tx_strobe === 1'b0, {tag, " strobe drop"}, {31'b0, tx_strobe}, 32'h0);
  endtask

  task automatic push(input logic [7:0] b);
    dev_q.push_back(b);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_irq(input bit e, input string tag);
    @(negedge clk);
    chk(irq === e, tag, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    automatic logic [7:0] id_tab[8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(12'h000, 32'h0, 0, "R1 ctrl");
    rd(12'h00C, 32'h0, 0, "R1 div");
    rd(12'h004, 32'h40, 0, "R1 stat");
    rd(12'h010, 32'h2, 0, "R1 irqst");
    rd(12'h008, 32'h0, 0, "R1 data");
    // R2 storage
    wr(12'h00C, 32'hA5A5_1234, 0, "R2 div wr");
    rd(12'h00C, 32'hA5A5_1234, 0, "R2 div");
    wr(12'h000, 32'h0000_0010, 0, "R2 ctrl wr");
    rd(12'h000, 32'h10, 0, "R2 ctrl");
    chk_irq(1'b0, "R6 no pending");
    // R3/R4/R6/R7 first byte
    push(8'h81);
    rd(12'h004, 32'h50, 0, "R3 stat pending");
    rd(12'h010, 32'h3, 0, "R7 irqst pending");
    chk_irq(1'b1, "R6 pending enabled");
    rd(12'h008, 32'h81, 1, "R4 pop 81");
    rd(12'h004, 32'h40, 0, "R3 parity even");
    chk_irq(1'b0, "R6 drained");
    rd(12'h010, 32'h2, 0, "R7 irqst idle");
    // parity from last read byte, not pending one
    push(8'h07);
    rd(12'h004, 32'h50, 0, "R3 parity of last read");
    rd(12'h008, 32'h07, 1, "R4 pop 07");
    rd(12'h004, 32'h44, 0, "R3 parity odd");
    // R5 re-read with empty port
    rd(12'h008, 32'h07, 0, "R5 reread");
    rd(12'h004, 32'h44, 0, "R5 stat kept");
    // back-to-back stream
    dev_q.push_back(8'h11);
    dev_q.push_back(8'h22);
    repeat (3) @(negedge clk);
    rd(12'h008, 32'h11, 1, "R4 stream 11");
    rd(12'h008, 32'h22, 1, "R4 stream 22");
    rd(12'h004, 32'h40, 0, "R3 stream done");
    // R6 force and gating
    wr(12'h000, 32'h08, 0, "R6 force wr");
    chk_irq(1'b1, "R6 forced");
    wr(12'h000, 32'h00, 0, "R6 clear wr");
    chk_irq(1'b0, "R6 cleared");
    push(8'h33);
    chk_irq(1'b0, "R6 pending disabled");
    wr(12'h000, 32'h10, 0, "R6 enable wr");
    chk_irq(1'b1, "R6 enabled late");
    rd(12'h008, 32'h33, 1, "R4 pop 33");
    chk_irq(1'b0, "R6 after pop");
    // R8 transmit
    wr(12'h008, 32'h0000_01F3, 1, "R8 tx F3");
    wr(12'h00A, 32'h0000_005C, 1, "R8 tx 5C");
    // R9 id window
    for (int i = 0; i < 8; i++)
      rd(12'hFE0 + 12'(4 * i), {24'b0, id_tab[i]}, 0, $sformatf("R9 id %0d", i));
    rd(12'hFE3, 32'h50, 0, "R9 id unaligned");
    // R10 unmapped
    rd(12'h014, 32'h0, 0, "R10 rd 014");
    rd(12'h800, 32'h0, 0, "R10 rd 800");
    rd(12'hFDC, 32'h0, 0, "R10 rd FDC");
    wr(12'h014, 32'hFFFF_FFFF, 0, "R10 wr 014");
    wr(12'h020, 32'hFFFF_FFFF, 0, "R10 wr 020");
    wr(12'hFE0, 32'hFFFF_FFFF, 0, "R10 wr id");
    rd(12'h000, 32'h10, 0, "R10 ctrl kept");
    rd(12'h00C, 32'hA5A5_1234, 0, "R10 div kept");
    rd(12'hFE0, 32'h50, 0, "R10 id kept");
    rd(12'h014, 32'h0, 0, "R10 still 0");
    chk_irq(1'b0, "R10 irq kept");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule